// File: doc/BRIEF.md
# Bus Request Priority Escalation Controller

This block produces the 2-bit priority level that a bus master shows to an arbiter while the master holds a request. The level runs from 0, the lowest, to 3, the highest, and the arbiter grants the higher level first. Each new request begins at a configured starting level. While the request waits without a grant, an interval timer runs, and every expiry raises the level by one step. Escalation stops at level 3.

An acknowledge, an abort or the withdrawal of the request ends the wait. The level then returns to the starting value, ready for the next request. A one-cycle timeout pulse is also brought out for debug; it marks the cycle just before each step.

Two elaboration-time parameters set the behaviour. `START_PRIO` takes a value from 0 to 4, and 4 pins the level at zero. `TIMEOUT` takes a value from 0 to 127 clocks, and 0 leaves out the timer altogether.

Top module: `prio_escalator`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows `prio_o` at the starting level and `tmo_pulse_o` at 0. The starting level is `START_PRIO` for values 0 to 3, and 0 when `START_PRIO` is 4.
- R2: A request starts at the first edge where `req_i` is 1 and both `ack_i` and `abort_i` are 0. From that edge until escalation, `prio_o` holds the starting level.
- R3: With escalation enabled, `prio_o` rises by exactly one level at edge number `TIMEOUT`+2 after the start edge, and again every `TIMEOUT`+2 edges after that. It never changes by any other amount, except to return to the starting level. Level 3 is the highest level and 0 the lowest.
- R4: `tmo_pulse_o` is 1 for exactly one cycle, the cycle just before each step. If the wait continues into the next edge, that edge raises the level by one.
- R5: Once `prio_o` is 3, it holds there and `tmo_pulse_o` stays 0 until the request ends.
- R6: An edge that samples `ack_i` high ends the request. In the next cycle `prio_o` is back at the starting level and `tmo_pulse_o` is 0, even when a step was due at that same edge.
- R7: An edge that samples `abort_i` high ends the request in the same way as R6.
- R8: An edge that samples `req_i` low ends a waiting request in the same way as R6.
- R9: With `START_PRIO` = 4, `prio_o` is always 0 and `tmo_pulse_o` is always 0.
- R10: With `TIMEOUT` = 0, `prio_o` stays at `START_PRIO` and `tmo_pulse_o` is always 0.
- R11: `ack_i` or `abort_i` pulses while no request is held leave `prio_o` and `tmo_pulse_o` unchanged. They also do not disturb the step timing of the request that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Master holds a request |
| ack_i | input | 1 | Arbiter acknowledged the request |
| abort_i | input | 1 | Master abandons the request |
| prio_o | output | 2 | Requested priority level, 3 highest |
| tmo_pulse_o | output | 1 | Debug pulse, one cycle before each step |

## Verification
Two events can land on the same edge: an acknowledge (or an abort) and the level step that a pending timeout pulse has scheduled. The bench provokes this by raising `ack_i` in the very cycle in which `tmo_pulse_o` is high. This is cycle `TIMEOUT`+1 after the start for the 5-clock configuration. The check is that the following cycle shows the starting level rather than the raised one. Several configurations, including timeouts of 1 and 127, run side by side from the same stimulus. Each is compared every cycle against a level computed from the edge count since the start.

// File: rtl/prio_esc_pkg.sv
// Package: shared types and elaboration helpers for the priority escalator.
// Assumes: the level field is 2 bits wide, with 3 as the highest level.
package prio_esc_pkg;

    typedef logic [1:0] prio_t;

    localparam prio_t PRIO_MAX = 2'd3;

    // Starting level for a START_PRIO setting; the value 4 pins the level at 0.
    function automatic prio_t start_level(input int setting);
        prio_t lvl;
        if (setting >= 4) begin
            lvl = 2'd0;
        end else begin
            lvl = prio_t'(setting);
        end
        return lvl;
    endfunction

    // True when both settings leave the escalation logic in place.
    function automatic bit esc_enabled(input int setting, input int timeout);
        return (setting < 4) && (timeout > 0);
    endfunction

endpackage

// File: rtl/esc_req_tracker.sv
// Module: esc_req_tracker
// Tracks whether a request is being held and flags the edge that starts one.
// Assumes: an acknowledge or an abort outranks a request that is still raised.
module esc_req_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_i,
    input  logic abort_i,
    output logic go_o,
    output logic active_o,
    output logic start_o
);

    // The request keeps waiting only while it is raised and not ended.
    always_comb begin
        go_o    = req_i && !ack_i && !abort_i;
        start_o = go_o && !active_o;
    end

    // Record whether a request was waiting after this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
        end else begin
            active_o <= go_o;
        end
    end

endmodule

// File: rtl/esc_interval_timer.sv
// Module: esc_interval_timer
// Counts one escalation interval and raises a registered one-cycle expiry.
// The counter reloads on the edge after the expiry, so expiries fall
// TIMEOUT+2 edges apart.
// Assumes: TIMEOUT >= 1; run_i drops once the level is saturated.
module esc_interval_timer #(
    parameter int TIMEOUT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic expire_o
);

    localparam int CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT);

    logic [CW-1:0] cnt_q;
    logic          at_zero;

    // The count has run out.
    always_comb begin
        at_zero = (cnt_q == '0);
    end

    // Load, count down, expire, reload; clear when the wait stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else if (start_i) begin
            cnt_q    <= RELOAD;
            expire_o <= 1'b0;
        end else if (run_i) begin
            if (expire_o) begin
                cnt_q    <= RELOAD;
                expire_o <= 1'b0;
            end else if (at_zero) begin
                expire_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end
    end

endmodule

// File: rtl/esc_level_reg.sv
// Module: esc_level_reg
// Holds the requested level. It steps up by one per expiry and returns to
// the starting level whenever the wait ends.
// Assumes: step_i is only high while the request keeps waiting.
module esc_level_reg
    import prio_esc_pkg::*;
#(
    parameter prio_t START_LVL = 2'd0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go_i,
    input  logic  step_i,
    output prio_t level_o,
    output logic  at_max_o
);

    // The level has reached the top.
    always_comb begin
        at_max_o = (level_o == PRIO_MAX);
    end

    // Return to the start on end or reset, otherwise step up once per expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_o <= START_LVL;
        end else if (!go_i) begin
            level_o <= START_LVL;
        end else if (step_i && !at_max_o) begin
            level_o <= level_o + 2'd1;
        end
    end

endmodule

// File: rtl/prio_escalator.sv
// Module: prio_escalator (top)
// Drives the priority level of a waiting bus request and raises it in timed
// steps. START_PRIO = 4 pins the level at 0, and TIMEOUT = 0 fixes it at
// START_PRIO. In both of those cases no timer is built.
// Assumes: inputs are synchronous to clk; the reset is synchronous and active low.
module prio_escalator
    import prio_esc_pkg::*;
#(
    parameter int START_PRIO = 0,
    parameter int TIMEOUT    = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       ack_i,
    input  logic       abort_i,
    output logic [1:0] prio_o,
    output logic       tmo_pulse_o
);

    localparam prio_t START_LVL = start_level(START_PRIO);
    localparam bit    ESC_ON    = esc_enabled(START_PRIO, TIMEOUT);

    if (ESC_ON) begin : g_esc
        logic  go;
        logic  active;
        logic  start;
        logic  run;
        logic  expire;
        logic  step;
        logic  at_max;
        prio_t level;

        esc_req_tracker u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_i),
            .ack_i    (ack_i),
            .abort_i  (abort_i),
            .go_o     (go),
            .active_o (active),
            .start_o  (start)
        );

        // The timer runs while a held request waits below the top level.
        always_comb begin
            run  = active && go && !at_max;
            step = active && go && expire;
        end

        esc_interval_timer #(
            .TIMEOUT (TIMEOUT)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start),
            .run_i    (run),
            .expire_o (expire)
        );

        esc_level_reg #(
            .START_LVL (START_LVL)
        ) u_level (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_i     (go),
            .step_i   (step),
            .level_o  (level),
            .at_max_o (at_max)
        );

        // Present the level and the debug pulse.
        always_comb begin
            prio_o      = level;
            tmo_pulse_o = expire;
        end
    end else begin : g_fixed
        logic unused_inputs;

        // The level is constant; no input affects it.
        always_comb begin
            unused_inputs = ^{clk, rst_n, req_i, ack_i, abort_i};
            prio_o        = START_LVL;
            tmo_pulse_o   = 1'b0;
        end
    end

endmodule

// File: rtl/prio_escalator_chk.sv
// Module: prio_escalator_chk
// Checker for prio_escalator, bound to every instance. It observes ports only.
// Assumes: the same parameters as the instance it is bound to.
module prio_escalator_chk
    import prio_esc_pkg::*;
#(
    parameter int START_PRIO = 0,
    parameter int TIMEOUT    = 31
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic       ack_i,
    input logic       abort_i,
    input logic [1:0] prio_o,
    input logic       tmo_pulse_o
);

    localparam prio_t START_LVL = start_level(START_PRIO);

    // A level change is one step up or a return to the start (R3).
    p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_o != $past(prio_o)) |->
            ((prio_o == START_LVL) || (prio_o == $past(prio_o) + 2'd1)));

    // A pulse followed by a continued wait raises the level (R4).
    p_pulse_then_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_pulse_o && req_i && !ack_i && !abort_i) |=>
            (prio_o == $past(prio_o) + 2'd1));

    // The pulse lasts a single cycle (R4).
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse_o |=> !tmo_pulse_o);

    // No pulse at the top level (R5).
    p_top_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_o == 2'd3) |-> !tmo_pulse_o);

    // An acknowledge restores the start (R6).
    p_ack_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> ((prio_o == START_LVL) && !tmo_pulse_o));

    // An abort restores the start (R7).
    p_abort_restores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> ((prio_o == START_LVL) && !tmo_pulse_o));

    // Withdrawing the request restores the start (R8).
    p_drop_restores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ((prio_o == START_LVL) && !tmo_pulse_o));

    if (START_PRIO >= 4) begin : g_pin
        // The level is pinned at zero (R9).
        p_pinned_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (prio_o == 2'd0) && !tmo_pulse_o);
    end else if (TIMEOUT == 0) begin : g_nofix
        // The level stays at the start value (R10).
        p_fixed_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (prio_o == START_LVL) && !tmo_pulse_o);
    end

endmodule

bind prio_escalator prio_escalator_chk #(
    .START_PRIO (START_PRIO),
    .TIMEOUT    (TIMEOUT)
) u_prio_escalator_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ack_i       (ack_i),
    .abort_i     (abort_i),
    .prio_o      (prio_o),
    .tmo_pulse_o (tmo_pulse_o)
);

// File: tb/prio_escalator_bench.sv
// Bench: six configurations of prio_escalator share one stimulus. Each
// directed task checks every configuration against a level computed from
// the number of edges since the request started.
module prio_escalator_bench;

    localparam int NCFG = 6;
    localparam int CFG_START [NCFG] = '{0, 0, 0, 2, 4, 1};
    localparam int CFG_TMO   [NCFG] = '{1, 5, 127, 3, 5, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       ack = 1'b0;
    logic       abort_s = 1'b0;
    logic [1:0] prio_w [NCFG];
    logic       tmo_w  [NCFG];

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        prio_escalator #(
            .START_PRIO (CFG_START[g]),
            .TIMEOUT    (CFG_TMO[g])
        ) u_prio_escalator (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (req),
            .ack_i       (ack),
            .abort_i     (abort_s),
            .prio_o      (prio_w[g]),
            .tmo_pulse_o (tmo_w[g])
        );
    end

    function automatic int start_of(input int c);
        return (CFG_START[c] >= 4) ? 0 : CFG_START[c];
    endfunction

    function automatic bit esc_of(input int c);
        return (CFG_START[c] < 4) && (CFG_TMO[c] > 0);
    endfunction

    // Expected level after edge k counted from the start edge (k = 0).
    function automatic int exp_prio(input int c, input int k);
        int lvl;
        if (!esc_of(c)) return start_of(c);
        lvl = start_of(c) + k / (CFG_TMO[c] + 2);
        return (lvl > 3) ? 3 : lvl;
    endfunction

    function automatic int exp_tmo(input int c, input int k);
        int m;
        if (!esc_of(c)) return 0;
        m = (k + 1) / (CFG_TMO[c] + 2);
        return (((k + 1) % (CFG_TMO[c] + 2)) == 0 && (start_of(c) + m - 1) < 3) ? 1 : 0;
    endfunction

    function automatic string tag_of(input int c, input int k);
        if (CFG_START[c] >= 4) return "R9";
        if (CFG_TMO[c] == 0) return "R10";
        if (exp_prio(c, k) == 3 && start_of(c) != 3) return "R5";
        if (k < CFG_TMO[c] + 2) return "R2";
        return "R3";
    endfunction

    task automatic check(input bit ok, input string rq, input int c,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s cfg%0d (start %0d, timeout %0d): actual %0d expected %0d",
                     rq, c, CFG_START[c], CFG_TMO[c], act, exp);
        end
    endtask

    // Every configuration is idle at its starting level.
    task automatic check_idle(input string rq);
        for (int c = 0; c < NCFG; c++) begin
            check(prio_w[c] == 2'(start_of(c)), rq, c, prio_w[c], start_of(c));
            check(tmo_w[c] == 1'b0, rq, c, tmo_w[c], 0);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Hold a request for n edges, checking each cycle against the model.
    task automatic run_wait(input int n);
        req = 1'b1;
        for (int k = 0; k < n; k++) begin
            tick();
            for (int c = 0; c < NCFG; c++) begin
                check(prio_w[c] == 2'(exp_prio(c, k)), tag_of(c, k), c,
                      prio_w[c], exp_prio(c, k));
                check(tmo_w[c] == 1'(exp_tmo(c, k)), "R4", c,
                      tmo_w[c], exp_tmo(c, k));
            end
        end
    endtask

    // End the request (0: drop, 1: acknowledge, 2: abort) and check the return.
    task automatic end_wait(input int how, input string rq);
        if (how == 0) req = 1'b0;
        if (how == 1) ack = 1'b1;
        if (how == 2) abort_s = 1'b1;
        tick();
        check_idle(rq);
        req = 1'b0;
        ack = 1'b0;
        abort_s = 1'b0;
        tick();
        check_idle(rq);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        check_idle("R1");
        rst_n = 1'b1;
        tick();
        check_idle("R1");
    endtask

    // Full escalation up to saturation for all configurations, then withdraw (R3, R5, R8).
    task automatic t_full_escalation();
        run_wait(400);
        end_wait(0, "R8");
    endtask

    // Acknowledge in the middle of an interval (R6).
    task automatic t_ack_mid();
        run_wait(10);
        end_wait(1, "R6");
    endtask

    // Acknowledge in the pulse cycle of the 5-clock configuration (R6).
    task automatic t_ack_on_step();
        run_wait(7);
        check(tmo_w[1] == 1'b1, "R6", 1, tmo_w[1], 1);
        end_wait(1, "R6");
    endtask

    // Abort partway through the wait (R7).
    task automatic t_abort();
        run_wait(20);
        end_wait(2, "R7");
    endtask

    // Idle acknowledge and abort change nothing; the next request times as usual (R11).
    task automatic t_idle_noise();
        ack = 1'b1;
        tick();
        check_idle("R11");
        ack = 1'b0;
        abort_s = 1'b1;
        tick();
        check_idle("R11");
        abort_s = 1'b0;
        tick();
        check_idle("R11");
        run_wait(30);
        end_wait(0, "R11");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_full_escalation();
        t_ack_mid();
        t_ack_on_step();
        t_abort();
        t_idle_noise();
        finish_run();
    end

endmodule